// File: doc/BRIEF.md
# Octal UART Host Glue

This block sits between a 32-bit host memory bus and two four-channel UART devices. It decodes an 8 KB address window. Part of the window goes to eight per-channel UART register windows. The rest goes to a small set of local byte-wide registers: one control register, two FIFO-readiness status registers and one interrupt status register. For channel windows it produces a one-hot chip select, a read or write strobe, the in-window byte offset and the write byte. It returns the UART read byte to the host.

The control register drives several lines: a common reset to both UARTs, an oscillator choice, a 1x/4x clock choice for each UART, and a global interrupt enable. The enable gates the OR of the eight UART interrupt pins onto one interrupt output. The readiness and interrupt pins of the UARTs are asynchronous. Each passes through a two-flop synchronizer before the host can read it.

Host accesses are single-cycle read or write strobes with byte enables. Read data is combinational in the strobe cycle. Every register sits in byte lane 0 of its 32-bit word, so 8-, 16- and 32-bit accesses all reach it through bit 0 of the byte enables.

Top module: `muart_glue`

## Requirements
- R1: A read or write with byte enable bit 0 set, at byte offset 0x00-0x7F of a channel window, asserts exactly one `uart_cs_o` bit for that access cycle. The windows are channels 1-4 at 0x0000/0x0100/0x0200/0x0300 and channels 5-8 at 0x1000/0x1100/0x1200/0x1300. Channel n drives bit n-1. The access also asserts `uart_rd_o` or `uart_wr_o` and puts the address bits 6:0 on `uart_addr_o`. Offsets 0x80-0xFF of a window, and pages 0x04xx, 0x08xx and 0x0Cxx, select no channel.
- R2: A channel read returns `uart_rdata_i` in `bus_rdata_o[7:0]` with bits 31:8 zero. A channel write puts `bus_wdata_i[7:0]` on `uart_wdata_o`.
- R3: The control register sits at 0x0500. Bits 4:0 are writable and reset to 0. A read returns `osc_present_i` in bit 7 and zero in bits 6:5.
- R4: After the clock edge that completes a control write, the outputs follow the register bits. `uart_rst_o` follows bit 4, `osc_sel_o` bit 3, `clk_sel_o[1]` bit 1 and `clk_sel_o[0]` bit 0. Without a control write they hold their value.
- R5: `irq_o` is high exactly when control bit 2 is 1 and at least one synchronized UART interrupt pin is high.
- R6: The readiness register for channels 1-4 is at 0x0600 and the one for channels 5-8 is at 0x1600. Each reads {rx_rdy of channels 4..1 (8..5), tx_rdy of channels 4..1 (8..5)}, with receive in bits 7:4. Both read 0xF0 after reset, and host writes to them change nothing.
- R7: The interrupt status register at 0x0700 reads the synchronized interrupt pins with channel n in bit n-1. Host writes to it change nothing, and `irq_o` gating does not alter it.
- R8: A pin change applied between edges appears in register reads after two rising edges. After one edge the read still shows the old value.
- R9: Reads of unmapped offsets return zero. Examples are 0x1500, 0x1700 and 0x0504. Writes to them change no register.
- R10: An access with byte enable bit 0 clear reaches no register and no channel. 16- and 32-bit accesses with bit 0 set behave as byte accesses on lane 0.
- R11: `bus_rdata_o` is zero whenever `bus_rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 13 | Byte address within the window |
| bus_rd_i | input | 1 | Read strobe, one cycle |
| bus_wr_i | input | 1 | Write strobe, one cycle |
| bus_be_i | input | 4 | Byte enables |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the strobe cycle |
| osc_present_i | input | 1 | Optional oscillator fitted |
| uart_irq_i | input | 8 | UART interrupt pins, channel n at bit n-1 |
| rx_rdy_i | input | 8 | Receive readiness pins, active low |
| tx_rdy_i | input | 8 | Transmit trigger-reached pins |
| uart_rdata_i | input | 8 | Read byte from the selected UART |
| uart_cs_o | output | 8 | One-hot channel select |
| uart_rd_o | output | 1 | UART read strobe |
| uart_wr_o | output | 1 | UART write strobe |
| uart_addr_o | output | 7 | Byte offset inside the channel window |
| uart_wdata_o | output | 8 | Write byte to the UART |
| uart_rst_o | output | 1 | Reset to both UARTs |
| osc_sel_o | output | 1 | 1 selects oscillator 1, 0 oscillator 2 |
| clk_sel_o | output | 2 | Per UART: 1 selects 1x clock, 0 selects 4x |
| irq_o | output | 1 | Gated interrupt |

## Verification
The assertions assume the host never raises read and write in the same cycle. They also assume a strobe lasts one cycle and its address and byte enables are stable while it is high. The bench drives every strobe on a falling edge and drops it one nanosecond after the next rising edge. No two accesses overlap. The asynchronous pins are changed only on falling edges, one step at a time, so the bench can predict the two-edge synchronizer delay exactly.

// File: rtl/muart_pkg.sv
package muart_pkg;
  localparam int ADDR_W      = 13;
  localparam int NUM_UART    = 2;
  localparam int CH_PER_UART = 4;
  localparam int NUM_CH      = NUM_UART * CH_PER_UART;
  localparam int SUB_W       = $clog2(CH_PER_UART);
  localparam int CH_IDX_W    = $clog2(NUM_CH);
  localparam int CTRL_W      = 5;

  localparam int CB_CLK0 = 0;
  localparam int CB_CLK1 = 1;
  localparam int CB_IEN  = 2;
  localparam int CB_OSC  = 3;
  localparam int CB_RST  = 4;

  // {addr[12], addr[11:8]} page codes of the local registers
  localparam logic [4:0] PG_CTRL   = 5'h05;
  localparam logic [4:0] PG_FRR_LO = 5'h06;
  localparam logic [4:0] PG_GISR   = 5'h07;
  localparam logic [4:0] PG_FRR_HI = 5'h16;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_CHAN,
    TGT_CTRL,
    TGT_FRR_LO,
    TGT_FRR_HI,
    TGT_GISR
  } tgt_e;
endpackage

// File: rtl/muart_decode.sv
module muart_decode
  import muart_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              be0_i,
  output tgt_e              tgt_o,
  output logic [NUM_CH-1:0] chan_o
);
  logic [3:0]          page;
  logic                hi;
  logic [CH_IDX_W-1:0] ch_idx;

  assign page   = addr_i[11:8];
  assign hi     = addr_i[ADDR_W-1];
  assign ch_idx = {hi, addr_i[8 +: SUB_W]};

  always_comb begin
    tgt_o = TGT_NONE;
    if (be0_i) begin
      if (page[3:2] == 2'b00 && !addr_i[7]) begin
        tgt_o = TGT_CHAN;
      end else if (addr_i[7:2] == '0) begin
        case ({hi, page})
          PG_CTRL:   tgt_o = TGT_CTRL;
          PG_FRR_LO: tgt_o = TGT_FRR_LO;
          PG_FRR_HI: tgt_o = TGT_FRR_HI;
          PG_GISR:   tgt_o = TGT_GISR;
          default:   tgt_o = TGT_NONE;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign chan_o[g] = (tgt_o == TGT_CHAN) && (ch_idx == CH_IDX_W'(g));
  end
endmodule

// File: rtl/muart_ctrl_reg.sv
module muart_ctrl_reg
  import muart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_o <= '0;
    else if (we_i) ctrl_o <= wdata_i;
  end

  a_r4_ctrl_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ctrl_o == $past(wdata_i));

  a_r4_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctrl_o));
endmodule

// File: rtl/muart_sync.sv
module muart_sync #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/muart_glue.sv
module muart_glue
  import muart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [12:0]       bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [3:0]        bus_be_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              osc_present_i,
  input  logic [7:0]        uart_irq_i,
  input  logic [7:0]        rx_rdy_i,
  input  logic [7:0]        tx_rdy_i,
  input  logic [7:0]        uart_rdata_i,
  output logic [7:0]        uart_cs_o,
  output logic              uart_rd_o,
  output logic              uart_wr_o,
  output logic [6:0]        uart_addr_o,
  output logic [7:0]        uart_wdata_o,
  output logic              uart_rst_o,
  output logic              osc_sel_o,
  output logic [1:0]        clk_sel_o,
  output logic              irq_o
);
  tgt_e              tgt;
  logic [NUM_CH-1:0] chan;
  logic [CTRL_W-1:0] ctrl;
  logic [NUM_CH-1:0] rx_s, tx_s, irq_s;
  logic              ctrl_we;
  logic [7:0]        rd_byte;
  logic              unused_bits;

  assign unused_bits = ^{bus_wdata_i[31:8], bus_be_i[3:1]};

  muart_decode u_dec (
    .addr_i (bus_addr_i),
    .be0_i  (bus_be_i[0]),
    .tgt_o  (tgt),
    .chan_o (chan)
  );

  assign ctrl_we = bus_wr_i && (tgt == TGT_CTRL);

  muart_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we),
    .wdata_i (bus_wdata_i[CTRL_W-1:0]),
    .ctrl_o  (ctrl)
  );

  muart_sync #(.W(NUM_CH), .RST_VAL({NUM_CH{1'b1}})) u_sync_rx (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (rx_rdy_i), .q_o (rx_s));
  muart_sync #(.W(NUM_CH), .RST_VAL('0)) u_sync_tx (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (tx_rdy_i), .q_o (tx_s));
  muart_sync #(.W(NUM_CH), .RST_VAL('0)) u_sync_irq (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (uart_irq_i), .q_o (irq_s));

  // channel side
  assign uart_cs_o    = (bus_rd_i || bus_wr_i) ? chan : '0;
  assign uart_rd_o    = bus_rd_i && (tgt == TGT_CHAN);
  assign uart_wr_o    = bus_wr_i && (tgt == TGT_CHAN);
  assign uart_addr_o  = bus_addr_i[6:0];
  assign uart_wdata_o = bus_wdata_i[7:0];

  // control lines
  assign uart_rst_o = ctrl[CB_RST];
  assign osc_sel_o  = ctrl[CB_OSC];
  assign clk_sel_o  = {ctrl[CB_CLK1], ctrl[CB_CLK0]};
  assign irq_o      = ctrl[CB_IEN] && (|irq_s);

  always_comb begin
    case (tgt)
      TGT_CHAN:   rd_byte = uart_rdata_i;
      TGT_CTRL:   rd_byte = {osc_present_i, 2'b00, ctrl};
      TGT_FRR_LO: rd_byte = {rx_s[CH_PER_UART-1:0], tx_s[CH_PER_UART-1:0]};
      TGT_FRR_HI: rd_byte = {rx_s[NUM_CH-1:CH_PER_UART], tx_s[NUM_CH-1:CH_PER_UART]};
      TGT_GISR:   rd_byte = irq_s;
      default:    rd_byte = '0;
    endcase
  end

  assign bus_rdata_o = bus_rd_i ? {24'h0, rd_byte} : '0;

  a_r1_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(uart_cs_o));

  a_r10_be0_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_be_i[0] |-> (uart_cs_o == '0) && !uart_rd_o && !uart_wr_o);

  a_r11_rdata_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |-> bus_rdata_o == '0);

  a_r1_strobe_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uart_rd_o || uart_wr_o) |-> $countones(uart_cs_o) == 1);
endmodule

// File: tb/muart_glue_test.sv
`timescale 1ns/1ps
module muart_glue_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [12:0] bus_addr = '0;
  logic        bus_rd = 0, bus_wr = 0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        osc_present = 1;
  logic [7:0]  uart_irq = '0, rx_rdy = 8'hFF, tx_rdy = '0, uart_rdata = 8'h5A;
  logic [7:0]  uart_cs, uart_wdata;
  logic        uart_rd, uart_wr, uart_rst, osc_sel, irq;
  logic [6:0]  uart_addr;
  logic [1:0]  clk_sel;

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  muart_glue uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(bus_addr), .bus_rd_i(bus_rd),
    .bus_wr_i(bus_wr), .bus_be_i(bus_be), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .osc_present_i(osc_present), .uart_irq_i(uart_irq),
    .rx_rdy_i(rx_rdy), .tx_rdy_i(tx_rdy), .uart_rdata_i(uart_rdata),
    .uart_cs_o(uart_cs), .uart_rd_o(uart_rd), .uart_wr_o(uart_wr),
    .uart_addr_o(uart_addr), .uart_wdata_o(uart_wdata), .uart_rst_o(uart_rst),
    .osc_sel_o(osc_sel), .clk_sel_o(clk_sel), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data and compares during each read cycle
  initial forever begin
    @(negedge clk); #1;
    if (bus_rd) begin
      if (exp_q.size() == 0) chk("read without expectation", 1, 0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic rd(logic [12:0] a, logic [3:0] be, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_rd = 1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1 bus_rd = 0;
  endtask

  task automatic wr(logic [12:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  // channel access with strobe-side checks
  task automatic chan(logic [12:0] a, logic [3:0] be, bit w, logic [7:0] d,
                      logic [7:0] exp_cs, logic [31:0] exp_rd, string tag);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = {24'hABCDEF, d};
    if (w) bus_wr = 1;
    else begin
      bus_rd = 1; exp_q.push_back(exp_rd); tag_q.push_back({tag, " rdata"});
    end
    #1;
    chk({tag, " cs"}, uart_cs, exp_cs);
    chk({tag, " strobe"}, {uart_rd, uart_wr},
        (exp_cs == 0) ? 2'b00 : (w ? 2'b01 : 2'b10));
    if (exp_cs != 0) chk({tag, " addr"}, uart_addr, a[6:0]);
    if (w && exp_cs != 0) chk({tag, " wdata"}, uart_wdata, d);
    @(posedge clk); #1 bus_rd = 0; bus_wr = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);
    #1;
    chk("R3 reset outputs", {uart_rst, osc_sel, clk_sel, irq}, 5'b0);
    chk("R11 idle rdata", bus_rdata, 0);
    rd(13'h0500, 4'h1, 32'h80, "R3 reset ctrl");
    rd(13'h0600, 4'h1, 32'hF0, "R6 reset frr lo");
    rd(13'h1600, 4'h1, 32'hF0, "R6 reset frr hi");
    rd(13'h0700, 4'h1, 32'h00, "R7 reset gisr");

    wr(13'h0500, 4'h1, 32'h1B);
    chk("R4 ctrl outputs", {uart_rst, osc_sel, clk_sel}, 4'b1111);
    chk("R5 irq off no pins", irq, 0);
    rd(13'h0500, 4'h1, 32'h9B, "R3 ctrl readback");
    osc_present = 0;
    rd(13'h0500, 4'h1, 32'h1B, "R3 osc present bit");
    wr(13'h0500, 4'h1, 32'hFF);
    rd(13'h0500, 4'h1, 32'h1F, "R3 reserved bits zero");
    wr(13'h0500, 4'h1, 32'h02);
    chk("R4 clk sel only", {uart_rst, osc_sel, clk_sel}, 4'b0010);
    wr(13'h0500, 4'h1, 32'h00);
    chk("R4 cleared", {uart_rst, osc_sel, clk_sel}, 4'b0000);

    wr(13'h0500, 4'b1110, 32'h1F1F1F1F);
    rd(13'h0500, 4'h1, 32'h00, "R10 be0 clear ignored");
    chk("R10 outputs unchanged", {uart_rst, osc_sel, clk_sel}, 4'b0000);
    wr(13'h0500, 4'hF, 32'h00000004);
    rd(13'h0500, 4'hF, 32'h04, "R10 32-bit access");

    @(negedge clk); uart_irq = 8'h20;
    idle(3); #1;
    chk("R5 irq enabled", irq, 1);
    rd(13'h0700, 4'h3, 32'h20, "R7 gisr ch6");
    wr(13'h0500, 4'h1, 32'h00);
    chk("R5 irq masked", irq, 0);
    wr(13'h0700, 4'h1, 32'h00);
    rd(13'h0700, 4'h1, 32'h20, "R7 gisr unchanged by mask and write");
    @(negedge clk); uart_irq = 8'h00;
    wr(13'h0500, 4'h1, 32'h04);
    idle(3); #1;
    chk("R5 irq no pins", irq, 0);

    @(negedge clk); rx_rdy = 8'hFD;
    rd(13'h0600, 4'h1, 32'hF0, "R8 one edge old");
    rd(13'h0600, 4'h1, 32'hD0, "R8 two edges new");

    @(negedge clk); tx_rdy = 8'h40;
    idle(3);
    rd(13'h1600, 4'h1, 32'hF4, "R6 frr hi tx ch7");
    wr(13'h1600, 4'h1, 32'h00);
    rd(13'h1600, 4'h1, 32'hF4, "R6 frr hi write ignored");
    wr(13'h0600, 4'h1, 32'h00);
    rd(13'h0600, 4'h1, 32'hD0, "R6 frr lo write ignored");

    chan(13'h1310, 4'h1, 0, 8'h00, 8'h80, 32'h5A, "R1 R2 ch8 read");
    uart_rdata = 8'hC3;
    chan(13'h0004, 4'hF, 0, 8'h00, 8'h01, 32'hC3, "R2 ch1 read 32-bit");
    chan(13'h0210, 4'h1, 1, 8'h33, 8'h04, 0, "R2 ch3 write");
    chan(13'h107F, 4'h1, 1, 8'h44, 8'h10, 0, "R1 ch5 top byte");
    chan(13'h0080, 4'h1, 0, 8'h00, 8'h00, 32'h0, "R1 gap in window");
    chan(13'h0400, 4'h1, 0, 8'h00, 8'h00, 32'h0, "R1 page 4 unmapped");
    chan(13'h0800, 4'h1, 1, 8'h55, 8'h00, 0, "R1 page 8 unmapped");
    chan(13'h1000, 4'b1110, 0, 8'h00, 8'h00, 32'h0, "R10 chan be0 clear");

    rd(13'h1500, 4'h1, 32'h0, "R9 reserved 1500");
    rd(13'h1700, 4'h1, 32'h0, "R9 reserved 1700");
    rd(13'h0504, 4'h1, 32'h0, "R9 ctrl neighbour");
    wr(13'h1500, 4'h1, 32'hFF);
    wr(13'h0504, 4'h1, 32'hFF);
    rd(13'h0500, 4'h1, 32'h04, "R9 writes ignored");
    chk("R9 outputs unchanged", {uart_rst, osc_sel, clk_sel}, 4'b0000);

    idle(2);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule